// File: doc/BRIEF.md
# Windowed Single-Shot Block Mover

The block copies one contiguous run of bytes between a private on-chip buffer and external memory. Software programs a source address, a destination address and a byte count, then writes a command word. The command word sets the direction, starts the job and can ask for a completion interrupt. One of the two addresses always points into a fixed address window that maps the buffer. The other address is an external byte address. The engine reaches external memory through a plain request/response master port and moves one byte per handshake.

The transfer does not start at once. It waits a programmable number of clock cycles after the start command. It then checks the window-side range. A range that does not fit inside the window aborts the job before any bus traffic and sets a sticky error flag. External addresses are cut to a parameterised width. While a job is in flight every register write is dropped, so the job parameters cannot change under the engine.

Top module: `dma_win_engine`

## Requirements
- R1: After reset the source, destination, count and command registers read as zero. No master request and no interrupt is driven until a command is accepted.
- R2: The registers are decoded at offsets 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command).
  - An 8-byte access (`reg_wide_i`=1) moves all 64 bits.
  - A 4-byte write stores the low 32 data bits with the upper half cleared.
  - A 4-byte read returns the low 32 bits with the upper half zero.
  - Any other offset reads as all ones in the bytes accessed.
- R3: While the run bit is set, writes to every register are ignored. This includes the command register.
- R4: A command write with bit 0 clear is discarded completely. The command register keeps its value and no transfer starts.
- R5: The first master request rises exactly START_DLY+1 clock edges after the edge that accepted the command write.
- R6: Direction 0 (command bit 1 clear) reads external bytes at ascending addresses `src+i` and stores each into buffer byte `dst-0x40000+i`, for i = 0 .. count-1.
- R7: Direction 1 (command bit 1 set) writes to external addresses `dst+i` the buffer bytes `src-0x40000+i`, in ascending order.
- R8: The window-side address A and count N are valid only if all of these hold: A ≥ 0x40000, N > 0, and A+N ≤ 0x41000 (computed without overflow). An invalid range causes three things:
  - no master request is made;
  - the run bit clears;
  - command bit 31 sets, and it clears again on the next accepted command.
- R9: Each external byte address is `(base+i)` ANDed with 2^EXT_AW−1, with EXT_AW = 28 by default. Addresses therefore wrap inside the 28-bit space.
- R10: The run bit clears on the edge that completes the last handshake. In that cycle `irq_o` pulses for one cycle, but only if command bit 2 was set.
- R11: A request stays asserted with a stable address until the response arrives. Each handshake moves exactly one byte. Command readback layout is: bit 0 run, bit 1 direction, bit 2 interrupt enable, bit 31 range error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wide_i | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| mem_req_o | output | 1 | Master request, held until response |
| mem_we_o | output | 1 | 1 = write to external memory, 0 = read |
| mem_addr_o | output | 64 | Masked external byte address |
| mem_wdata_o | output | 8 | Byte written to external memory |
| mem_rsp_i | input | 1 | Response; completes the handshake on this edge |
| mem_rdata_i | input | 8 | Byte returned for a read |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the range test at its exact edges:
- a window start one byte below the base;
- a run that ends one byte past the top;
- a zero count;
- a count large enough to overflow a 64-bit sum.

A design with an off-by-one compare, or one that checks with a wrapping adder, would either move data it should refuse or refuse a run that ends exactly at the top.

External addresses near 2^28 check that the mask is applied to every byte address rather than only to the base, so the sequence must wrap to zero. Round trips under several response stall patterns catch three faults: a design that advances without a response, one that moves its address while stalled, or one that indexes the buffer from the wrong base, all of which produce read-back bytes that differ from the computed pattern. The bench also writes to registers while a transfer runs, and writes a command without the run bit. A design with a missing lock or a command filter would be seen to change the job or the readback.

// File: rtl/dma_win_pkg.sv
package dma_win_pkg;
  localparam logic [7:0] OFF_SRC = 8'h80;
  localparam logic [7:0] OFF_DST = 8'h88;
  localparam logic [7:0] OFF_CNT = 8'h90;
  localparam logic [7:0] OFF_CMD = 8'h98;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IRQ = 2;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_MOVE
  } seq_state_e;
endpackage

// File: rtl/dma_win_regs.sv
module dma_win_regs
  import dma_win_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic        wide_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] rdata_o,
  input  logic        done_i,
  input  logic        abort_i,
  output logic        start_o,
  output logic [63:0] src_o,
  output logic [63:0] dst_o,
  output logic [63:0] cnt_o,
  output logic        dir_o,
  output logic        irq_en_o,
  output logic        run_o
);
  logic [63:0] src_q, dst_q, cnt_q, wval, rfull;
  logic run_q, dir_q, irq_en_q, err_q, wr_ok;

  assign wval    = wide_i ? wdata_i : {32'h0, wdata_i[31:0]};
  assign wr_ok   = we_i && !run_q;
  assign start_o = wr_ok && (addr_i == OFF_CMD) && wdata_i[CMD_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      dir_q    <= 1'b0;
      irq_en_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (done_i) run_q <= 1'b0;
      if (abort_i) begin
        run_q <= 1'b0;
        err_q <= 1'b1;
      end
      if (wr_ok) begin
        unique case (addr_i)
          OFF_SRC: src_q <= wval;
          OFF_DST: dst_q <= wval;
          OFF_CNT: cnt_q <= wval;
          OFF_CMD: if (wval[CMD_RUN]) begin
            run_q    <= 1'b1;
            dir_q    <= wval[CMD_DIR];
            irq_en_q <= wval[CMD_IRQ];
            err_q    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_SRC: rfull = src_q;
      OFF_DST: rfull = dst_q;
      OFF_CNT: rfull = cnt_q;
      OFF_CMD: rfull = {32'h0, err_q, 28'h0, irq_en_q, dir_q, run_q};
      default: rfull = '1;
    endcase
    rdata_o = wide_i ? rfull : {32'h0, rfull[31:0]};
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign cnt_o    = cnt_q;
  assign dir_o    = dir_q;
  assign irq_en_o = irq_en_q;
  assign run_o    = run_q;

  // R3
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && we_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
endmodule

// File: rtl/dma_win_seq.sv
module dma_win_seq
  import dma_win_pkg::*;
#(
  parameter int          BUF_AW    = 12,
  parameter logic [63:0] WIN_BASE  = 64'h40000,
  parameter int          EXT_AW    = 28,
  parameter int          START_DLY = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [63:0]       src_i,
  input  logic [63:0]       dst_i,
  input  logic [63:0]       cnt_i,
  input  logic              dir_i,
  output logic              done_o,
  output logic              abort_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_rsp_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i
);
  localparam int          BUF_BYTES = 1 << BUF_AW;
  localparam int          DLY_W     = $clog2(START_DLY + 1);
  localparam logic [64:0] WIN_END   = {1'b0, WIN_BASE} + 65'(BUF_BYTES);
  localparam logic [63:0] EXT_MASK  = (64'd1 << EXT_AW) - 64'd1;
  localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(START_DLY);

  seq_state_e       st_q;
  logic [DLY_W-1:0] dly_q;
  logic [BUF_AW:0]  idx_q;
  logic [63:0]      win_addr, ext_base, idx_ext;
  logic             range_ok, last_byte, xfer;

  // job registers are locked while running, so they are read directly
  always_comb begin
    win_addr  = dir_i ? src_i : dst_i;
    ext_base  = dir_i ? dst_i : src_i;
    idx_ext   = {{(63-BUF_AW){1'b0}}, idx_q};
    range_ok  = (win_addr >= WIN_BASE) && (cnt_i != '0) &&
                (({1'b0, win_addr} + {1'b0, cnt_i}) <= WIN_END);
    last_byte = (idx_ext == cnt_i - 64'd1);
  end

  assign xfer        = (st_q == SQ_MOVE);
  assign mem_req_o   = xfer;
  assign mem_we_o    = xfer && dir_i;
  assign mem_addr_o  = (ext_base + idx_ext) & EXT_MASK;
  assign mem_wdata_o = buf_rdata_i;
  assign buf_addr_o  = win_addr[BUF_AW-1:0] - WIN_BASE[BUF_AW-1:0] + idx_q[BUF_AW-1:0];
  assign buf_we_o    = xfer && !dir_i && mem_rsp_i;
  assign buf_wdata_o = mem_rdata_i;
  assign done_o      = xfer && mem_rsp_i && last_byte;
  assign abort_o     = (st_q == SQ_WAIT) && (dly_q == '0) && !range_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      dly_q <= '0;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q  <= SQ_WAIT;
          dly_q <= DLY_INIT;
        end
        SQ_WAIT: begin
          if (dly_q != '0) dly_q <= dly_q - 1'b1;
          else if (range_ok) begin
            st_q  <= SQ_MOVE;
            idx_q <= '0;
          end else st_q <= SQ_IDLE;
        end
        SQ_MOVE: if (mem_rsp_i) begin
          if (last_byte) st_q <= SQ_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R11
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8
  abort_nomove_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !mem_req_o);
endmodule

// File: rtl/dma_win_buf.sv
module dma_win_buf #(
  parameter int BUF_AW = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [BUF_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int BUF_BYTES = 1 << BUF_AW;

  logic [7:0] mem_q [BUF_BYTES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/dma_win_engine.sv
module dma_win_engine #(
  parameter int          BUF_AW    = 12,
  parameter logic [63:0] WIN_BASE  = 64'h40000,
  parameter int          EXT_AW    = 28,
  parameter int          START_DLY = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_wide_i,
  input  logic [63:0] reg_wdata_i,
  output logic [63:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [63:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic        mem_rsp_i,
  input  logic [7:0]  mem_rdata_i,
  output logic        irq_o
);
  logic [63:0]       src, dst, cnt;
  logic              dir, irq_en, run, start, done, abort;
  logic              buf_we;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0]        buf_wdata, buf_rdata;

  dma_win_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wide_i(reg_wide_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .done_i(done), .abort_i(abort), .start_o(start),
    .src_o(src), .dst_o(dst), .cnt_o(cnt),
    .dir_o(dir), .irq_en_o(irq_en), .run_o(run)
  );

  dma_win_seq #(
    .BUF_AW(BUF_AW), .WIN_BASE(WIN_BASE), .EXT_AW(EXT_AW), .START_DLY(START_DLY)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .src_i(src), .dst_i(dst), .cnt_i(cnt), .dir_i(dir),
    .done_o(done), .abort_o(abort),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rsp_i, .mem_rdata_i,
    .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata)
  );

  dma_win_buf #(.BUF_AW(BUF_AW)) u_buf (
    .clk_i, .we_i(buf_we), .addr_i(buf_addr),
    .wdata_i(buf_wdata), .rdata_o(buf_rdata)
  );

  assign irq_o = done && irq_en;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!mem_req_o && !irq_o));

  // R10
  irq_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (run && mem_rsp_i));

  // R10
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !run);
endmodule

// File: tb/sim_dma_win_engine.sv
module sim_dma_win_engine;
  localparam int          DLY  = 16;
  localparam logic [63:0] BASE = 64'h40000;
  localparam logic [63:0] MSK  = 64'h0FFF_FFFF;
  localparam logic [7:0]  A_SRC = 8'h80, A_DST = 8'h88, A_CNT = 8'h90, A_CMD = 8'h98;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0, reg_wide_i = 1'b1, mem_rsp_i = 1'b0;
  logic [7:0]  reg_addr_i = '0, mem_rdata_i = '0;
  logic [63:0] reg_wdata_i = '0, reg_rdata_o, mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic mem_req_o, mem_we_o, irq_o;

  int n_run = 0, n_fail = 0;
  int stall = 0, wait_ctr = 0;
  int lg_total = 0, irq_total = 0;
  logic [63:0] lg_addr [4096];
  logic        lg_we   [4096];
  logic [7:0]  lg_data [4096];

  always #5 clk = ~clk;

  dma_win_engine u0 (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wide_i, .reg_wdata_i,
    .reg_rdata_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rsp_i, .mem_rdata_i, .irq_o
  );

  function automatic logic [7:0] ext_byte(logic [63:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  // external memory model: responds after `stall` waiting cycles
  always @(negedge clk) begin
    if (mem_rsp_i) wait_ctr = 0;
    if (mem_req_o && wait_ctr >= stall) mem_rsp_i = 1'b1;
    else begin
      mem_rsp_i = 1'b0;
      if (mem_req_o) wait_ctr++;
    end
    mem_rdata_i = ext_byte(mem_addr_o);
  end

  always @(posedge clk) begin
    if (irq_o) irq_total++;
    if (mem_req_o && mem_rsp_i) begin
      lg_addr[lg_total % 4096] = mem_addr_o;
      lg_we[lg_total % 4096]   = mem_we_o;
      lg_data[lg_total % 4096] = mem_we_o ? mem_wdata_o : mem_rdata_i;
      lg_total++;
    end
  end

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [63:0] d, logic wide);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wide_i = wide; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, logic wide, output logic [63:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wide_i = wide; reg_we_i = 1'b0;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_idle();
    logic [63:0] c;
    int g = 0;
    do begin
      reg_rd(A_CMD, 1'b1, c);
      g++;
    end while (c[0] && g < 20000);
  endtask

  // programs and runs one job; returns cycles to first request and log base
  task automatic run_job(logic [63:0] s, logic [63:0] d, logic [63:0] n,
                         logic [63:0] cmd, output int dly, output int base, output int irqs);
    int t = 0, i0;
    reg_wr(A_SRC, s, 1'b1);
    reg_wr(A_DST, d, 1'b1);
    reg_wr(A_CNT, n, 1'b1);
    base = lg_total;
    i0 = irq_total;
    reg_wr(A_CMD, cmd, 1'b1);
    while (!mem_req_o && t < DLY + 20) begin
      @(negedge clk);
      t++;
    end
    dly = t;
    wait_idle();
    irqs = irq_total - i0;
  endtask

  task automatic round_trip(logic [63:0] s, int off, int n, logic [63:0] d);
    int dly, base, irqs, errs;
    logic [63:0] c;
    run_job(s, BASE + 64'(off), 64'(n), 64'h1, dly, base, irqs);
    chk("R5 start delay", 64'(dly), 64'(DLY + 1));
    chk("R6 read count", 64'(lg_total - base), 64'(n));
    errs = 0;
    for (int i = 0; i < n; i++)
      if (lg_we[(base + i) % 4096] !== 1'b0 ||
          lg_addr[(base + i) % 4096] !== ((s + 64'(i)) & MSK)) errs++;
    chk("R6 R9 R11 read addresses", 64'(errs), 64'd0);
    chk("R10 no irq without enable", 64'(irqs), 64'd0);
    run_job(BASE + 64'(off), d, 64'(n), 64'h7, dly, base, irqs);
    chk("R7 write count", 64'(lg_total - base), 64'(n));
    errs = 0;
    for (int i = 0; i < n; i++)
      if (lg_we[(base + i) % 4096] !== 1'b1 ||
          lg_addr[(base + i) % 4096] !== ((d + 64'(i)) & MSK) ||
          lg_data[(base + i) % 4096] !== ext_byte((s + 64'(i)) & MSK)) errs++;
    chk("R7 R9 written bytes", 64'(errs), 64'd0);
    chk("R10 irq pulse", 64'(irqs), 64'd1);
    reg_rd(A_CMD, 1'b1, c);
    chk("R10 R11 cmd after done", c, 64'h6);
  endtask

  task automatic bad_range(logic [63:0] s, logic [63:0] d, logic [63:0] n, logic dir);
    int dly, base, irqs;
    logic [63:0] c;
    run_job(s, d, n, {61'h0, 1'b0, dir, 1'b1}, dly, base, irqs);
    chk("R8 no request on bad range", 64'(lg_total - base), 64'd0);
    reg_rd(A_CMD, 1'b1, c);
    chk("R8 error flag and run clear", c, 64'h8000_0000 | {62'h0, dir, 1'b0});
  endtask

  initial begin
    #(10 * 190000);
    n_run++; n_fail++;
    $display("FAIL R10 watchdog act=%0d exp=0", 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] src_tab [3];
    int cnt_tab [4];
    int dly, base, irqs;
    src_tab[0] = 64'h0000_0000_0000_0100;
    src_tab[1] = 64'hABCD_0000_0A00_0010;
    src_tab[2] = 64'h0000_0000_0FFF_FFFD;
    cnt_tab[0] = 1; cnt_tab[1] = 2; cnt_tab[2] = 5; cnt_tab[3] = 64;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    reg_rd(A_SRC, 1'b1, v); chk("R1 src reset", v, 64'h0);
    reg_rd(A_DST, 1'b1, v); chk("R1 dst reset", v, 64'h0);
    reg_rd(A_CNT, 1'b1, v); chk("R1 cnt reset", v, 64'h0);
    reg_rd(A_CMD, 1'b1, v); chk("R1 cmd reset", v, 64'h0);
    chk("R1 no request", {63'h0, mem_req_o}, 64'h0);
    chk("R1 no irq", {63'h0, irq_o}, 64'h0);

    // R2 access widths and decode
    reg_wr(A_SRC, 64'h0123_4567_89AB_CDEF, 1'b1);
    reg_rd(A_SRC, 1'b1, v); chk("R2 wide readback", v, 64'h0123_4567_89AB_CDEF);
    reg_rd(A_SRC, 1'b0, v); chk("R2 narrow read", v, 64'h0000_0000_89AB_CDEF);
    reg_wr(A_CNT, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    reg_wr(A_CNT, 64'hFFFF_FFFF_1111_2222, 1'b0);
    reg_rd(A_CNT, 1'b1, v); chk("R2 narrow write", v, 64'h0000_0000_1111_2222);
    reg_rd(8'h40, 1'b1, v); chk("R2 unmapped read", v, 64'hFFFF_FFFF_FFFF_FFFF);

    // R4 command without run bit
    reg_wr(A_CMD, 64'h6, 1'b1);
    repeat (DLY + 4) @(negedge clk);
    chk("R4 no request", {63'h0, mem_req_o}, 64'h0);
    reg_rd(A_CMD, 1'b1, v); chk("R4 cmd unchanged", v, 64'h0);

    // R6 R7 R9 R11 sweep over count, buffer offset, stall, external base
    for (int ci = 0; ci < 4; ci++)
      for (int oi = 0; oi < 3; oi++) begin
        int off;
        off = (oi == 0) ? 0 : (oi == 1) ? 37 : 4096 - cnt_tab[ci];
        stall = (ci + oi) % 3;
        round_trip(src_tab[(ci + oi) % 3], off, cnt_tab[ci],
                   64'h0FFF_FFF0 + 64'(oi * 8));
      end

    // full window
    stall = 0;
    round_trip(64'h0000_0000_0123_0000, 0, 4096, 64'h0000_0000_0200_0000);

    // R8 range edges
    bad_range(64'h100, BASE - 64'd1, 64'd1, 1'b0);
    bad_range(64'h100, BASE + 64'd4093, 64'd4, 1'b0);
    bad_range(64'h100, BASE, 64'd0, 1'b0);
    bad_range(BASE + 64'd4096, 64'h100, 64'd1, 1'b1);
    bad_range(64'h100, BASE + 64'd16, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0);
    run_job(64'h300, BASE + 64'd4092, 64'd4, 64'h1, dly, base, irqs);
    chk("R8 top-edge range accepted", 64'(lg_total - base), 64'd4);
    reg_rd(A_CMD, 1'b1, v); chk("R8 error cleared by new command", v, 64'h0);

    // R3 writes during a running job
    stall = 12;
    reg_wr(A_SRC, 64'h500, 1'b1);
    reg_wr(A_DST, BASE, 1'b1);
    reg_wr(A_CNT, 64'd3, 1'b1);
    base = lg_total;
    reg_wr(A_CMD, 64'h1, 1'b1);
    reg_wr(A_SRC, 64'h9999, 1'b1);
    reg_wr(A_CNT, 64'd1, 1'b1);
    reg_wr(A_CMD, 64'h7, 1'b1);
    wait_idle();
    reg_rd(A_SRC, 1'b1, v); chk("R3 src locked", v, 64'h500);
    reg_rd(A_CNT, 1'b1, v); chk("R3 cnt locked", v, 64'd3);
    reg_rd(A_CMD, 1'b1, v); chk("R3 cmd locked", v, 64'h0);
    chk("R3 job unchanged", 64'(lg_total - base), 64'd3);
    chk("R3 first address", lg_addr[base % 4096], 64'h500);
    stall = 0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule